// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock

This block is the watchdog of a small microcontroller. It counts ticks of a slow timebase, supplied as a one-cycle enable, up to a timeout that software picks. Each time the CPU executes its watchdog-reset instruction, a restart strobe clears the count. If software stops sending the strobe, the count expires. The block then raises an interrupt request, or pulses a system reset, or does both in turn: first the interrupt, then a reset on the next expiry. A sticky flag in a reset status register records that the watchdog caused the reset.

Software configures the watchdog through one 8-bit control register on a simple register port. The timeout selection and the reset enable are protected. A write changes them only if it lands shortly after a key write that set both the key bit and the reset-enable bit. A stray store therefore cannot switch the watchdog off or stretch its period. The interrupt enable is not protected. Hardware clears it when the interrupt fires, so an unserviced second expiry resets the chip.

Top module: `wdt_guard`

## Requirements
- R1: After `rst`, the control register reads 0x00 (select 0, reset and interrupt disabled), the status register reads 0x00, and `irq` and `sys_rst` are low.
- R2: Control register layout: select bits [2:0] at bits 2..0, reset enable at bit 3, key bit at bit 4 (always reads 0), select bit [3] at bit 5, interrupt enable at bit 6, bit 7 reads 0.
- R3: A write with bits 4 and 3 both set opens an unlock window. A control write that lands 1 to UNLOCK_CYCLES cycles after the most recent opening write is accepted and updates the select and the reset enable. Any other write leaves them unchanged. An opening write that lands inside an open window is itself accepted and reopens the window.
- R4: Every control write updates the interrupt enable from bit 6, whether or not the window is open.
- R5: While the reset enable or the interrupt enable is set, the block counts slow ticks. The timeout is (2^BASE_LOG2 << select) ticks, measured from the last accepted write or restart.
- R6: The restart strobe clears the count. A restart in the same cycle as the expiring tick wins, and the full timeout starts again.
- R7: On expiry with the interrupt enable clear and the reset enable set, `sys_rst` is high for exactly one cycle, starting the cycle after the expiring tick. Status bit 3 is set on the same edge.
- R8: On expiry with the interrupt enable set, `irq` pulses for one cycle and `sys_rst` stays low. The interrupt enable is cleared on the same edge, and this hardware clear wins over a CPU write in that cycle.
- R9: With both enables clear, nothing is counted, and neither `sys_rst` nor `irq` is ever raised.
- R10: Status bit 3 stays set until a status write with bit 3 equal to 0. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable from the slow timebase |
| restart | input | 1 | Watchdog restart strobe from the CPU |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status register write data |
| sts_rdata | output | 8 | Status register read data (bit 3 = watchdog reset flag) |
| irq | output | 1 | Watchdog interrupt request, one-cycle pulse |
| sys_rst | output | 1 | System reset request, one-cycle pulse |

## Verification
The restart strobe and the expiring tick can land in the same cycle, and so can an accepted configuration write and an expiring tick. The bench provokes the first by sweeping the restart position up to and including the exact expiry tick. It provokes the second with a window-reopening write that lands on the fourth tick of a select-0 timeout. In both cases it judges that no pulse appears and that the next expiry arrives one full timeout later. It also lands a CPU write of the interrupt enable on the expiry edge and expects the hardware clear to win.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CR_W    = 8;
  localparam int SEL_W   = 4;
  localparam int B_EN    = 3;
  localparam int B_KEY   = 4;
  localparam int B_SEL3  = 5;
  localparam int B_IE    = 6;
  localparam int ST_FLAG = 3;

  typedef struct packed {
    logic             ie;
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;

  function automatic logic [SEL_W-1:0] sel_of(input logic [CR_W-1:0] v);
    return {v[B_SEL3], v[2:0]};
  endfunction

  function automatic logic [CR_W-1:0] cr_pack(input wdt_cfg_t c);
    logic [CR_W-1:0] r;
    r          = '0;
    r[2:0]     = c.sel[2:0];
    r[B_EN]    = c.en;
    r[B_SEL3]  = c.sel[3];
    r[B_IE]    = c.ie;
    return r;
  endfunction
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic key,
  output logic win_open
);
  localparam int LW = $clog2(WINDOW + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)               left <= '0;
    else if (wr && key)    left <= LW'(WINDOW);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign win_open = (left != '0);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_LOG2 = 11,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = (CNT_W'(1) << (BASE_LOG2 + int'(sel))) - 1'b1;
  assign expire = run && tick && !clear && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (tick)            cnt <= expire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_LOG2     = 11,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_tick,
  input  logic       restart,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       sts_we,
  input  logic [7:0] sts_wdata,
  output logic [7:0] sts_rdata,
  output logic       irq,
  output logic       sys_rst
);
  import wdt_pkg::*;

  wdt_cfg_t cfg;
  logic     flag;
  logic     win_open;
  logic     accept;
  logic     expire;
  logic     fire_rst;
  logic     fire_irq;

  wdt_unlock #(.WINDOW(UNLOCK_CYCLES)) u_unlock (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_we),
    .key      (cfg_wdata[B_KEY] && cfg_wdata[B_EN]),
    .win_open (win_open)
  );

  assign accept = cfg_we && win_open;

  wdt_count #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .run    (cfg.en || cfg.ie),
    .clear  (restart || accept),
    .tick   (slow_tick),
    .sel    (cfg.sel),
    .expire (expire)
  );

  assign fire_irq = expire && cfg.ie;
  assign fire_rst = expire && !cfg.ie && cfg.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (cfg_we) cfg.ie <= cfg_wdata[B_IE];
      if (accept) begin
        cfg.en  <= cfg_wdata[B_EN];
        cfg.sel <= sel_of(cfg_wdata);
      end
      if (fire_irq) cfg.ie <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      sys_rst <= 1'b0;
      flag    <= 1'b0;
    end else begin
      irq     <= fire_irq;
      sys_rst <= fire_rst;
      if (fire_rst)                         flag <= 1'b1;
      else if (sts_we && !sts_wdata[ST_FLAG]) flag <= 1'b0;
    end
  end

  assign cfg_rdata = cr_pack(cfg);
  assign sts_rdata = 8'(flag) << ST_FLAG;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       restart,
  input logic       cfg_we,
  input logic       win_open,
  input logic [7:0] cfg_rdata,
  input logic [7:0] sts_rdata,
  input logic       irq,
  input logic       sys_rst
);
  assert_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && win_open) |=> $stable({cfg_rdata[5], cfg_rdata[3:0]}));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> !(irq || sys_rst));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !sys_rst);

  assert_flag_R7: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> sts_rdata[3]);

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(irq && sys_rst));

  assert_ieclr_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> !cfg_rdata[6]);

  assert_off_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[3] |=> !sys_rst);
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .restart   (restart),
  .cfg_we    (cfg_we),
  .win_open  (win_open),
  .cfg_rdata (cfg_rdata),
  .sts_rdata (sts_rdata),
  .irq       (irq),
  .sys_rst   (sys_rst)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  localparam int BL = 2;
  localparam int UW = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_tick = 1'b1;
  logic       restart = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sts_we = 1'b0;
  logic [7:0] sts_wdata = 8'h00;
  logic [7:0] sts_rdata;
  logic       irq;
  logic       sys_rst;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BL), .UNLOCK_CYCLES(UW)) i_wdt_guard (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .restart(restart),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic sw(input logic [7:0] v);
    sts_we = 1'b1; sts_wdata = v;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input logic [7:0] v);
    wr(8'h18);
    wr(v);
  endtask

  // Counts from the negedge after the accepted write; outcome expected at cycle e.
  task automatic expiry(input int e, input int r, input bit want_irq, input string req);
    for (int k = 1; k <= e; k++) begin
      restart = (k == r);
      @(negedge clk);
      restart = 1'b0;
      if (k < e)
        chk(!sys_rst && !irq, req, {30'd0, irq, sys_rst}, 32'd0);
      else if (want_irq)
        chk(irq && !sys_rst && !cfg_rdata[6], req, {29'd0, cfg_rdata[6], irq, sys_rst}, 32'd2);
      else
        chk(sys_rst && !irq && sts_rdata[3], req, {29'd0, sts_rdata[3], irq, sys_rst}, 32'd5);
    end
  endtask

  initial begin
    int sels[7] = '{0, 1, 2, 3, 4, 7, 9};
    int rs[4] = '{1, 3, 7, 8};
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 8'h00 && sts_rdata == 8'h00 && !irq && !sys_rst, "R1",
        {16'd0, cfg_rdata, sts_rdata}, 32'd0);

    // R3: protected fields ignore unlocked writes
    wr(8'h07);
    chk(cfg_rdata == 8'h00, "R3 no unlock", cfg_rdata, 32'h00);
    wr(8'h28);
    chk(cfg_rdata == 8'h00, "R3 no unlock en", cfg_rdata, 32'h00);

    // R3/R2: window position sweep
    for (int d = 1; d <= 6; d++) begin
      wr(8'h18);
      idle(d - 1);
      wr(8'h13);
      chk(cfg_rdata == ((d <= UW) ? 8'h03 : 8'h00), "R3 window", cfg_rdata,
          (d <= UW) ? 32'h03 : 32'h00);
      setcfg(8'h00);
      idle(6);
    end

    // R3: reopening write restarts the window; it also lands on an expiring tick
    wr(8'h18);
    idle(2);
    wr(8'h18);
    chk(cfg_rdata == 8'h08, "R3 reopen accepted", cfg_rdata, 32'h08);
    idle(3);
    wr(8'h02);
    chk(cfg_rdata == 8'h02 && !sys_rst, "R3 reopen window", {23'd0, sys_rst, cfg_rdata}, 32'h02);
    setcfg(8'h00);
    idle(6);

    // R5/R7/R2: timeout per select
    foreach (sels[i]) begin
      logic [7:0] v;
      v = 8'h08 | 8'(sels[i] & 7) | ((sels[i] > 7) ? 8'h20 : 8'h00);
      setcfg(v | 8'h10);
      chk(cfg_rdata == v, "R2 readback", cfg_rdata, v);
      expiry((1 << BL) << sels[i], 0, 1'b0, "R5 R7 timeout");
      @(negedge clk);
      chk(!sys_rst, "R7 one cycle", sys_rst, 0);
      setcfg(8'h00);
      if (i == 0) begin
        sw(8'h08);
        chk(sts_rdata == 8'h08, "R10 kept", sts_rdata, 32'h08);
      end
      sw(8'h00);
      chk(sts_rdata == 8'h00, "R10 cleared", sts_rdata, 32'h00);
    end

    // R6: restart strobe positions, including the expiring tick
    foreach (rs[i]) begin
      setcfg(8'h09);
      expiry(rs[i] + 8, rs[i], 1'b0, "R6 restart");
      setcfg(8'h00);
      sw(8'h00);
    end

    // R8: interrupt then reset
    setcfg(8'h48);
    expiry(4, 0, 1'b1, "R8 irq first");
    expiry(4, 0, 1'b0, "R8 then reset");
    setcfg(8'h00);
    sw(8'h00);

    // R8: hardware clear wins over a same-cycle write of the enable
    setcfg(8'h48);
    idle(3);
    wr(8'h40);
    chk(irq && cfg_rdata == 8'h08, "R8 clear wins", {23'd0, irq, cfg_rdata}, 32'h108);
    setcfg(8'h00);
    sw(8'h00);

    // R4: interrupt-only mode, enable set without unlock
    wr(8'h40);
    chk(cfg_rdata == 8'h40, "R4 ie write", cfg_rdata, 32'h40);
    expiry(4, 0, 1'b1, "R4 irq only");
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(!irq && !sys_rst, "R8 stopped", {30'd0, irq, sys_rst}, 0);
    end

    // R9: disabled watchdog stays quiet
    setcfg(8'h08);
    idle(2);
    setcfg(8'h00);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      chk(!irq && !sys_rst, "R9 disabled", {30'd0, irq, sys_rst}, 0);
    end
    chk(sts_rdata == 8'h00, "R9 no flag", sts_rdata, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule